// File: doc/BRIEF.md
# Two-wire write-only target receiver

This block is the target side of a two-wire serial bus for a small peripheral whose registers are only written from the host. It runs on a system clock that is much faster than the serial clock. It passes the raw SCL and SDA lines through a synchroniser, finds START, repeated START and STOP conditions, and shifts in an address byte. It acknowledges the byte when the address is its own write address, and after that it acknowledges each data byte that follows.

The address is a fixed five-bit prefix followed by two bits taken from board strap inputs. Tying both strap inputs low turns the interface off. Each accepted data byte appears on a one-cycle strobe, together with its position in the current transfer. The data line output is a pull-down enable that drives an open-drain pad.

Top module: `twi_write_target`

## Requirements
- R1: After reset, sda_pull and rx_valid are 0 and rx_index is 0. The block ignores the bus until it sees a START.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Data bits are sampled on each SCL rising edge, most significant bit first.
- R3: The block acknowledges an address byte only when all of these hold: bits 7..3 are 10010, bit 2 equals strap_hi, bit 1 equals strap_lo, and bit 0 (the R/W bit, 0 = write) is 0. For any other address byte, including a read request, it gives no acknowledge. It then acknowledges nothing and reports no data until the next START or STOP.
- R4: A STOP at any bit position ends the transfer. A partly received byte is dropped without a strobe, and the block returns to idle.
- R5: The block asserts sda_pull after the falling edge of the 8th SCL clock of an accepted byte and releases it after the falling edge of the 9th clock. SDA stays low through the whole high period of the 9th clock.
- R6: While strap_hi and strap_lo are both 0, the block never asserts sda_pull and never asserts rx_valid.
- R7: After the acknowledge clock of each data byte, rx_valid is high for exactly one clock cycle. In that cycle rx_data holds the byte.
- R8: In the rx_valid cycle, rx_index gives the position of the byte in the transfer. It counts 0, 1, 2 and so on, and restarts at 0 after each START or repeated START.
- R9: A repeated START restarts address reception without a STOP before it. This also holds after an address was refused.
- R10: A STOP seen within the same SCL-high pulse as a START is ignored, and the block goes on to receive the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line, as seen at the pad |
| strap_hi | input | 1 | Strap bit placed in address bit 2 |
| strap_lo | input | 1 | Strap bit placed in address bit 1 |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| rx_valid | output | 1 | One-cycle strobe for a received data byte |
| rx_data | output | 8 | Received data byte |
| rx_index | output | IDX_W | Position of the byte in the current transfer |

## Verification
The bench tests several address cases: a foreign address, a read request, both strap settings with a single 1 (so that swapped strap bits would acknowledge the wrong address), and the all-zero strap setting (where a design that does not disable itself would acknowledge). It sends a STOP halfway through a byte and checks that no strobe follows, which catches a design that flushes the partial byte. It sends a repeated START mid-transfer and checks that rx_index restarts at 0. It also raises and lowers SDA within a single SCL-high pulse: a design that takes that edge as a STOP would then refuse the next address.

// File: rtl/twi_pkg.sv
// Shared types and constants for the two-wire write-only target.
// Assumes: one receiver per bus line pair.
package twi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a START
        ST_ADDR,   // shifting in the address byte
        ST_AACK,   // driving the address acknowledge
        ST_DATA,   // shifting in a data byte
        ST_DACK,   // driving the data acknowledge
        ST_SKIP    // address refused, wait for START or STOP
    } twi_state_e;

    localparam logic [4:0] ADDR_PREFIX = 5'b10010;
    localparam int         BYTE_BITS   = 8;
endpackage

// File: rtl/twi_sync.sv
// Multi-stage synchroniser for the SCL and SDA lines.
// Assumes: lines idle high, so the flops reset to 1.
module twi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s
);
    logic [1:0] raw;
    logic [1:0] synced;

    assign raw   = {scl_raw, sda_raw};
    assign scl_s = synced[1];
    assign sda_s = synced[0];

    for (genvar ln = 0; ln < 2; ln++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift each line through its own flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[ln]};
        end
        assign synced[ln] = chain[STAGES-1];
    end
endmodule

// File: rtl/twi_cond.sv
// Finds SCL edges and START/STOP conditions on the synchronised lines.
// A STOP that follows a START inside the same SCL-high pulse is suppressed.
// Assumes: inputs already synchronised to clk.
module twi_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q, start_in_pulse, stop_raw;

    // Keep the previous synchronised values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_raw  = scl_s & scl_q & ~sda_q & sda_s;
    assign stop_det  = stop_raw & ~start_in_pulse;

    // Remember that the current SCL-high pulse already carried a START.
    always_ff @(posedge clk) begin
        if (!rst_n)         start_in_pulse <= 1'b0;
        else if (!scl_s)    start_in_pulse <= 1'b0;
        else if (start_det) start_in_pulse <= 1'b1;
    end
endmodule

// File: rtl/twi_rx.sv
// Byte receiver: address compare, acknowledge and data strobe.
// Assumes: one-cycle event pulses from twi_cond, and SCL much slower than clk.
module twi_rx
    import twi_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       my_addr,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_pull,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic [IDX_W-1:0] rx_index
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

    twi_state_e       state;
    logic [CNT_W-1:0] bitcnt;
    logic [7:0]       shreg;
    logic [IDX_W-1:0] byte_cnt;
    logic             addr_hit;

    assign addr_hit = (shreg == {ADDR_PREFIX, my_addr, 1'b0});

    // Main sequencer: bus conditions take priority over bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            byte_cnt <= '0;
            sda_pull <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_index <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!enable || stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (start_det) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                byte_cnt <= '0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise && bitcnt < FULL) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == FULL) begin
                            if (state == ST_DATA) begin
                                sda_pull <= 1'b1;
                                state    <= ST_DACK;
                            end else if (addr_hit) begin
                                sda_pull <= 1'b1;
                                state    <= ST_AACK;
                            end else begin
                                state    <= ST_SKIP;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                            state    <= ST_DATA;
                        end
                    end
                    ST_DACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                            state    <= ST_DATA;
                            rx_valid <= 1'b1;
                            rx_data  <= shreg;
                            rx_index <= byte_cnt;
                            byte_cnt <= byte_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/twi_write_target.sv
// Top of the two-wire write-only target: synchroniser, condition
// detector and byte receiver. Assumes straps change only while idle.
module twi_write_target #(
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             strap_hi,
    input  logic             strap_lo,
    output logic             sda_pull,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic [IDX_W-1:0] rx_index
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    twi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_s(scl_s), .sda_s(sda_s)
    );

    twi_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twi_rx #(.IDX_W(IDX_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .enable(strap_hi | strap_lo),
        .my_addr({strap_hi, strap_lo}), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_pull(sda_pull), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_index(rx_index)
    );
endmodule

// File: rtl/twi_write_target_chk.sv
// Property checker for twi_write_target, attached with bind.
// Assumes: a well-behaved bus master (no START during an acknowledge).
module twi_write_target_chk (
    input logic clk,
    input logic rst_n,
    input logic strap_hi,
    input logic strap_lo,
    input logic sda_pull,
    input logic rx_valid,
    input logic scl_s,
    input logic scl_fall,
    input logic stop_det
);
    AST_OFF_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(strap_hi | strap_lo) |=> (!sda_pull && !rx_valid)); // R6

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7

    AST_STROBE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(scl_fall)); // R7

    AST_ACK_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !stop_det) |-> $stable(sda_pull)); // R5

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_pull && !rx_valid)); // R4
endmodule

bind twi_write_target twi_write_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .strap_lo(strap_lo),
    .sda_pull(sda_pull), .rx_valid(rx_valid), .scl_s(scl_s),
    .scl_fall(scl_fall), .stop_det(stop_det)
);

// File: tb/sim_twi_write_target.sv
// Scoreboard bench: the driver queues the strobes it expects, and the monitor
// pops them as the design reports bytes.
module sim_twi_write_target;
    localparam int IDX_W = 4;
    localparam int Q     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic strap_hi = 1'b1, strap_lo = 1'b1;
    logic sda_pull, rx_valid;
    logic [7:0] rx_data;
    logic [IDX_W-1:0] rx_index;
    wire  sda_line = sda_m & ~sda_pull;

    int n_chk = 0, n_bad = 0;
    int exp_idx = 0;
    bit finished = 1'b0;
    logic [IDX_W+7:0] exp_q[$];

    always #10 clk = ~clk;

    twi_write_target #(.IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .strap_hi(strap_hi), .strap_lo(strap_lo), .sda_pull(sda_pull),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_index(rx_index)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
        exp_idx = 0;
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    // Send a byte; exp_ack says whether an acknowledge is due, is_data whether a strobe follows.
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit is_data, input string req);
        if (exp_ack && is_data) begin
            exp_q.push_back({IDX_W'(exp_idx), b});
            exp_idx++;
        end
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        check(sda_line == !exp_ack, req, sda_line, !exp_ack);
        wq();
        check(sda_line == !exp_ack, req, sda_line, !exp_ack);
        scl_m = 1'b0; wq();
        check(sda_pull == 1'b0, "R5 release after 9th clock", sda_pull, 0);
    endtask

    // Monitor: every strobe must match the oldest queued item.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected strobe", {rx_index, rx_data}, 0);
            end else begin
                logic [IDX_W+7:0] e;
                e = exp_q.pop_front();
                check(rx_data == e[7:0], "R7 data", rx_data, e[7:0]);
                check(rx_index == e[IDX_W+7:8], "R8 index", rx_index, e[IDX_W+7:8]);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(sda_pull == 0 && rx_valid == 0 && rx_index == 0, "R1 reset state",
              {sda_pull, rx_valid, rx_index}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: bus traffic without a START is ignored
        send_byte(8'h96, 1'b0, 1'b0, "R1 no START no ack");

        // R2 R3 R7 R8: straps 11, write address 0x96, two data bytes
        do_start();
        send_byte(8'h96, 1'b1, 1'b0, "R3 address ack");
        send_byte(8'hA5, 1'b1, 1'b1, "R2 data ack");
        send_byte(8'h3C, 1'b1, 1'b1, "R8 second byte ack");
        do_stop();

        // R3: foreign address, then data ignored
        do_start();
        send_byte(8'h94, 1'b0, 1'b0, "R3 foreign address nack");
        send_byte(8'h55, 1'b0, 1'b0, "R3 data after refusal");
        // R9: repeated START after refusal is accepted
        do_start();
        send_byte(8'h96, 1'b1, 1'b0, "R9 address after refusal");
        send_byte(8'h01, 1'b1, 1'b1, "R9 data");
        do_stop();

        // R3: read request refused
        do_start();
        send_byte(8'h97, 1'b0, 1'b0, "R3 read nack");
        do_stop();

        // R9 R8: repeated START mid-transfer restarts index
        do_start();
        send_byte(8'h96, 1'b1, 1'b0, "R9 first address");
        send_byte(8'h11, 1'b1, 1'b1, "R9 byte before restart");
        send_byte(8'h12, 1'b1, 1'b1, "R9 byte before restart 2");
        do_start();
        send_byte(8'h96, 1'b1, 1'b0, "R9 restart address");
        send_byte(8'h22, 1'b1, 1'b1, "R8 index restarts");
        do_stop();

        // R4: STOP mid-byte discards partial data
        do_start();
        send_byte(8'h96, 1'b1, 1'b0, "R4 address");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        do_stop();
        check(sda_pull == 0, "R4 idle after STOP", sda_pull, 0);
        send_byte(8'h96, 1'b0, 1'b0, "R4 idle ignores bus");
        do_start();
        send_byte(8'h96, 1'b1, 1'b0, "R4 new transfer address");
        send_byte(8'h77, 1'b1, 1'b1, "R4 new transfer data");
        do_stop();

        // R10: START and STOP in one SCL-high pulse
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); sda_m = 1'b1; wq();
        scl_m = 1'b0; wq();
        exp_idx = 0;
        send_byte(8'h96, 1'b1, 1'b0, "R10 address after same-pulse STOP");
        send_byte(8'h5A, 1'b1, 1'b1, "R10 data");
        do_stop();

        // R3: strap order, straps hi=1 lo=0
        strap_hi = 1'b1; strap_lo = 1'b0; wq();
        do_start();
        send_byte(8'h92, 1'b0, 1'b0, "R3 swapped strap nack");
        do_start();
        send_byte(8'h94, 1'b1, 1'b0, "R3 strap hi address ack");
        send_byte(8'hC3, 1'b1, 1'b1, "R3 strap hi data");
        do_stop();

        // R3: straps hi=0 lo=1
        strap_hi = 1'b0; strap_lo = 1'b1; wq();
        do_start();
        send_byte(8'h94, 1'b0, 1'b0, "R3 swapped strap nack 2");
        do_start();
        send_byte(8'h92, 1'b1, 1'b0, "R3 strap lo address ack");
        do_stop();

        // R6: straps both low disable the interface
        strap_hi = 1'b0; strap_lo = 1'b0; wq();
        do_start();
        send_byte(8'h90, 1'b0, 1'b0, "R6 disabled address 0x90");
        send_byte(8'h42, 1'b0, 1'b0, "R6 disabled data");
        do_start();
        send_byte(8'h96, 1'b0, 1'b0, "R6 disabled address 0x96");
        do_stop();

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R7 all strobes seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule